// File: doc/BRIEF.md
# Buck Controller Protection Supervisor

This block is the synchronous fault supervisor of a single-phase synchronous buck controller. It receives comparator results that have already been brought into the clock domain: a per-switching-cycle valley over-current sample, two feedback over-voltage flags (a low threshold near 125% of reference and a high threshold near 162.5%), a feedback under-voltage flag (below about 75% of reference), a soft-start-done indication and the power-on reset. From these it produces gate-override commands for the upper and lower switches, a latched shutdown flag and a one-cycle restart request that re-launches soft-start.

Over-current trips only after a run of consecutive bad switching cycles and then latches. Over-voltage is soft and self-clearing while soft-start is still running, and becomes a latched trip at the higher threshold once soft-start is done. Under-voltage must persist for a programmable delay before it acts; it then holds both switches off for a programmable hiccup interval and asks for a restart. Latched states clear only through the power-on reset.

Top module: `buck_fault_supervisor`

## Requirements
- R1: On each cycle with `cyc_tick`=1, a run counter increments when `valley_oc`=1 and clears when `valley_oc`=0; cycles with `cyc_tick`=0 leave it unchanged. When the run reaches OC_TRIP_COUNT (default 4) the over-current latch sets, visible the cycle after the tick that completes the run.
- R2: With the over-current latch set (and no latched over-voltage), `hs_kill`=1, `ls_kill`=1, `ls_force`=0 and `shutdown`=1.
- R3: Latched over-current and latched over-voltage stay set whatever the inputs do, and clear only when `por_n` is driven low; all outputs are 0 in reset.
- R4: While `ss_done`=0, `fb_ov_low`=1 gives, one cycle later, `hs_kill`=1, `ls_force`=1, `ls_kill`=0 without `shutdown`; the override releases one cycle after the flag drops.
- R5: While `ss_done`=1, `fb_ov_low` alone has no effect; `fb_ov_high`=1 sets the over-voltage latch one cycle later, with `shutdown`=1.
- R6: Every over-voltage response (soft or latched) drives the upper switch off and the lower switch on: `hs_kill`=1, `ls_force`=1, `ls_kill`=0.
- R7: Under-voltage trips only after `fb_uv`=1 together with `ss_done`=1 for UV_DELAY_CYC consecutive cycles; a shorter run, or one with `ss_done`=0, has no effect. After the trip `hs_kill`=1 and `ls_kill`=1.
- R8: After an under-voltage trip both switches stay off for exactly HICCUP_CYC cycles; in the first cycle after that, the overrides release and `restart_req` is 1 for exactly one cycle.
- R9: Override priority: latched over-voltage over latched over-current, over-current over soft over-voltage, soft over-voltage over the under-voltage hiccup.
- R10: `restart_req` is never raised while `shutdown`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cyc_tick | input | 1 | One-cycle strobe marking the valley sample of a switching cycle |
| valley_oc | input | 1 | Valley current above trip level |
| fb_ov_low | input | 1 | Feedback above the lower over-voltage threshold |
| fb_ov_high | input | 1 | Feedback above the upper over-voltage threshold |
| fb_uv | input | 1 | Feedback below the under-voltage threshold |
| ss_done | input | 1 | Soft-start has completed |
| hs_kill | output | 1 | Force upper switch off |
| ls_kill | output | 1 | Force lower switch off |
| ls_force | output | 1 | Force lower switch on |
| shutdown | output | 1 | A latched fault is present |
| restart_req | output | 1 | One-cycle request to re-launch soft-start |

## Verification
On every cycle the assertions check that a latched shutdown never falls outside reset, that any shutdown keeps the upper switch off, that the lower switch is never forced both on and off, that each latch sets only after its qualifying input, and that the restart request is a lone pulse never raised under shutdown. The exact trip cycle of the over-current run and of the under-voltage delay, the length of the hiccup interval, the ignoring of inputs in each mode and the priority among coexisting faults are shown only by the bench's swept scenarios, which compute each expected cycle from the parameters.

// File: rtl/buck_prot_pkg.sv
package buck_prot_pkg;

  typedef enum logic {
    UV_WATCH = 1'b0,
    UV_REST  = 1'b1
  } uv_state_t;

  typedef struct packed {
    logic hs_kill;
    logic ls_kill;
    logic ls_force;
  } gate_ovr_t;

  // Fixed priority of fault responses onto the gate overrides.
  function automatic gate_ovr_t pick_override(input logic ov_latched,
                                              input logic oc_latched,
                                              input logic ov_soft,
                                              input logic uv_resting);
    gate_ovr_t g;
    g = '0;
    if (ov_latched) begin
      g.hs_kill  = 1'b1;
      g.ls_force = 1'b1;
    end else if (oc_latched) begin
      g.hs_kill = 1'b1;
      g.ls_kill = 1'b1;
    end else if (ov_soft) begin
      g.hs_kill  = 1'b1;
      g.ls_force = 1'b1;
    end else if (uv_resting) begin
      g.hs_kill = 1'b1;
      g.ls_kill = 1'b1;
    end
    return g;
  endfunction

endpackage

// File: rtl/oc_run_guard.sv
module oc_run_guard #(
  parameter int OC_TRIP_COUNT = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic cyc_tick,
  input  logic valley_oc,
  output logic oc_latched
);
  localparam int CW = $clog2(OC_TRIP_COUNT + 1);

  logic [CW-1:0] run_q;
  logic          run_done;

  assign run_done = (run_q == CW'(OC_TRIP_COUNT - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_q      <= '0;
      oc_latched <= 1'b0;
    end else if (cyc_tick) begin
      if (valley_oc) begin
        if (run_q != CW'(OC_TRIP_COUNT)) run_q <= run_q + 1'b1;
        if (run_done) oc_latched <= 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  // R1: latch sets only on a tick carrying an over-current sample
  a_r1_trip_needs_event: assert property (@(posedge clk) disable iff (!por_n)
    $rose(oc_latched) |-> $past(cyc_tick && valley_oc));

  // R3: once set, stays set until reset
  a_r3_oc_sticky: assert property (@(posedge clk) disable iff (!por_n)
    oc_latched |=> oc_latched);

endmodule

// File: rtl/ov_guard.sv
module ov_guard (
  input  logic clk,
  input  logic por_n,
  input  logic fb_ov_low,
  input  logic fb_ov_high,
  input  logic ss_done,
  output logic ov_soft,
  output logic ov_latched
);
  logic hard_hit;
  assign hard_hit = fb_ov_high && ss_done;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ov_soft    <= 1'b0;
      ov_latched <= 1'b0;
    end else begin
      ov_soft <= fb_ov_low && !ss_done;
      if (hard_hit) ov_latched <= 1'b1;
    end
  end

  // R4: soft response only while soft-start was running
  a_r4_soft_pre_ss: assert property (@(posedge clk) disable iff (!por_n)
    ov_soft |-> $past(!ss_done && fb_ov_low));

  // R5: latched trip only from the high threshold after soft-start
  a_r5_hard_source: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ov_latched) |-> $past(fb_ov_high && ss_done));

  // R3: sticky until reset
  a_r3_ov_sticky: assert property (@(posedge clk) disable iff (!por_n)
    ov_latched |=> ov_latched);

endmodule

// File: rtl/uv_hiccup.sv
module uv_hiccup
  import buck_prot_pkg::*;
#(
  parameter int UV_DELAY_CYC = 1000,
  parameter int HICCUP_CYC   = 50000
) (
  input  logic clk,
  input  logic por_n,
  input  logic fb_uv,
  input  logic ss_done,
  input  logic hold_off,
  output logic resting,
  output logic restart_req
);
  localparam int MAXC = (UV_DELAY_CYC > HICCUP_CYC) ? UV_DELAY_CYC : HICCUP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  uv_state_t     st_q;
  logic [CW-1:0] cnt_q;
  logic          uv_qual;
  logic          delay_hit;
  logic          rest_over;

  assign uv_qual   = fb_uv && ss_done;
  assign delay_hit = uv_qual && (cnt_q == CW'(UV_DELAY_CYC - 1));
  assign rest_over = (cnt_q == CW'(HICCUP_CYC - 1));
  assign resting   = (st_q == UV_REST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q        <= UV_WATCH;
      cnt_q       <= '0;
      restart_req <= 1'b0;
    end else begin
      restart_req <= 1'b0;
      case (st_q)
        UV_WATCH: begin
          if (delay_hit) begin
            st_q  <= UV_REST;
            cnt_q <= '0;
          end else if (uv_qual) begin
            cnt_q <= cnt_q + 1'b1;
          end else begin
            cnt_q <= '0;
          end
        end
        default: begin
          if (rest_over) begin
            st_q        <= UV_WATCH;
            cnt_q       <= '0;
            restart_req <= !hold_off;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R7: entering the rest interval needs a qualified under-voltage
  a_r7_rest_entry: assert property (@(posedge clk) disable iff (!por_n)
    $rose(resting) |-> $past(fb_uv && ss_done));

  // R8: restart is a single-cycle pulse following the rest interval
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
    restart_req |=> !restart_req);

  a_r8_after_rest: assert property (@(posedge clk) disable iff (!por_n)
    restart_req |-> $past(resting) && !resting);

endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
  import buck_prot_pkg::*;
#(
  parameter int OC_TRIP_COUNT = 4,
  parameter int UV_DELAY_CYC  = 1000,
  parameter int HICCUP_CYC    = 50000
) (
  input  logic clk,
  input  logic por_n,
  input  logic cyc_tick,
  input  logic valley_oc,
  input  logic fb_ov_low,
  input  logic fb_ov_high,
  input  logic fb_uv,
  input  logic ss_done,
  output logic hs_kill,
  output logic ls_kill,
  output logic ls_force,
  output logic shutdown,
  output logic restart_req
);
  logic      oc_latched;
  logic      ov_soft;
  logic      ov_latched;
  logic      uv_resting;
  logic      uv_restart;
  gate_ovr_t ovr;

  oc_run_guard #(.OC_TRIP_COUNT(OC_TRIP_COUNT)) oc_i (
    .clk(clk), .por_n(por_n), .cyc_tick(cyc_tick), .valley_oc(valley_oc),
    .oc_latched(oc_latched)
  );

  ov_guard ov_i (
    .clk(clk), .por_n(por_n), .fb_ov_low(fb_ov_low), .fb_ov_high(fb_ov_high),
    .ss_done(ss_done), .ov_soft(ov_soft), .ov_latched(ov_latched)
  );

  uv_hiccup #(.UV_DELAY_CYC(UV_DELAY_CYC), .HICCUP_CYC(HICCUP_CYC)) uv_i (
    .clk(clk), .por_n(por_n), .fb_uv(fb_uv), .ss_done(ss_done),
    .hold_off(oc_latched || ov_latched),
    .resting(uv_resting), .restart_req(uv_restart)
  );

  assign ovr         = pick_override(ov_latched, oc_latched, ov_soft, uv_resting);
  assign hs_kill     = ovr.hs_kill;
  assign ls_kill     = ovr.ls_kill;
  assign ls_force    = ovr.ls_force;
  assign shutdown    = oc_latched || ov_latched;
  assign restart_req = uv_restart;

  // R2: any shutdown keeps the upper switch off
  a_r2_shutdown_hs_off: assert property (@(posedge clk) disable iff (!por_n)
    shutdown |-> hs_kill);

  // R6: lower switch is never forced on and off together
  a_r6_ls_exclusive: assert property (@(posedge clk) disable iff (!por_n)
    !(ls_kill && ls_force));

  // R3: shutdown does not fall outside reset
  a_r3_shutdown_hold: assert property (@(posedge clk) disable iff (!por_n)
    shutdown |=> shutdown);

  // R10: no restart while latched
  a_r10_no_restart_latched: assert property (@(posedge clk) disable iff (!por_n)
    $past(shutdown) |-> !restart_req);

endmodule

// File: tb/buck_fault_supervisor_tb_top.sv
module buck_fault_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OCN = 4;
  localparam int UVD = 5;
  localparam int HIC = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic cyc_tick = 0, valley_oc = 0, fb_ov_low = 0, fb_ov_high = 0, fb_uv = 0, ss_done = 0;
  logic hs_kill, ls_kill, ls_force, shutdown, restart_req;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_fault_supervisor #(.OC_TRIP_COUNT(OCN), .UV_DELAY_CYC(UVD), .HICCUP_CYC(HIC)) dut_i (
    .clk(clk), .por_n(por_n), .cyc_tick(cyc_tick), .valley_oc(valley_oc),
    .fb_ov_low(fb_ov_low), .fb_ov_high(fb_ov_high), .fb_uv(fb_uv), .ss_done(ss_done),
    .hs_kill(hs_kill), .ls_kill(ls_kill), .ls_force(ls_force),
    .shutdown(shutdown), .restart_req(restart_req)
  );

  // outputs packed as {hs_kill, ls_kill, ls_force, shutdown, restart_req}
  localparam logic [4:0] O_NONE = 5'b00000;
  localparam logic [4:0] O_OC   = 5'b11010;
  localparam logic [4:0] O_OVL  = 5'b10110;
  localparam logic [4:0] O_OVS  = 5'b10100;
  localparam logic [4:0] O_UV   = 5'b11000;
  localparam logic [4:0] O_RST  = 5'b00001;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {hs_kill, ls_kill, ls_force, shutdown, restart_req};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    cyc_tick = 0; valley_oc = 0; fb_ov_low = 0; fb_ov_high = 0; fb_uv = 0; ss_done = 0;
    por_n = 0;
    step(2);
    por_n = 1;
    step(1);
  endtask

  task automatic oc_tick(input logic v);
    cyc_tick = 1; valley_oc = v;
    step(1);
    cyc_tick = 0; valley_oc = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    do_reset();
    check("R3 reset state", O_NONE);

    // R1 sweep of consecutive over-current runs
    for (int k = 1; k <= OCN + 2; k++) begin
      do_reset();
      for (int i = 0; i < k; i++) oc_tick(1);
      check("R1 run length", (k >= OCN) ? O_OC : O_NONE);
    end

    // R1 a clean cycle breaks the run
    do_reset();
    for (int i = 0; i < OCN - 1; i++) oc_tick(1);
    oc_tick(0);
    for (int i = 0; i < OCN - 1; i++) oc_tick(1);
    check("R1 clean cycle clears run", O_NONE);
    oc_tick(1);
    check("R1 run completes after break", O_OC);

    // R1 non-tick cycles do not reset the run
    do_reset();
    for (int i = 0; i < OCN - 1; i++) oc_tick(1);
    valley_oc = 0; step(6);
    oc_tick(1);
    check("R1 idle cycles keep run", O_OC);

    // R2/R3 latch survives input activity, cleared by reset
    fb_uv = 1; ss_done = 1; fb_ov_low = 1; step(UVD + HIC + 3);
    check("R2 R3 oc latch holds", O_OC);
    do_reset();
    check("R3 reset clears oc", O_NONE);

    // R4 soft over-voltage before soft-start done
    fb_ov_low = 1; step(1);
    check("R4 R6 soft ov", O_OVS);
    step(3);
    check("R4 soft ov holds", O_OVS);
    fb_ov_low = 0; step(1);
    check("R4 soft ov releases", O_NONE);
    fb_ov_high = 1; step(2);
    check("R5 high flag ignored pre-ss", O_NONE);
    fb_ov_high = 0;

    // R5 after soft-start
    ss_done = 1; fb_ov_low = 1; step(3);
    check("R5 low flag ignored post-ss", O_NONE);
    fb_ov_high = 1; step(1);
    check("R5 R6 latched ov", O_OVL);
    fb_ov_high = 0; fb_ov_low = 0; ss_done = 0; step(5);
    check("R3 ov latch holds", O_OVL);
    do_reset();
    check("R3 reset clears ov", O_NONE);

    // R7 under-voltage delay sweep
    for (int d = 1; d <= UVD + 1; d++) begin
      do_reset();
      ss_done = 1; fb_uv = 1;
      step(d);
      check("R7 uv delay", (d >= UVD) ? O_UV : O_NONE);
    end
    do_reset();
    fb_uv = 1; ss_done = 0; step(UVD + 3);
    check("R7 uv ignored during soft-start", O_NONE);
    ss_done = 1; step(UVD - 1); fb_uv = 0; step(1); fb_uv = 1; step(UVD - 1);
    check("R7 broken uv run", O_NONE);

    // R8 hiccup interval and restart pulse
    step(1);
    check("R7 uv trips", O_UV);
    fb_uv = 0;
    step(HIC - 1);
    check("R8 still resting", O_UV);
    step(1);
    check("R8 restart pulse", O_RST);
    step(1);
    check("R8 pulse is single", O_NONE);

    // R9 priorities
    do_reset();
    for (int i = 0; i < OCN; i++) oc_tick(1);
    fb_ov_low = 1; step(2);
    check("R9 oc over soft ov", O_OC);
    fb_ov_low = 0; ss_done = 1; fb_ov_high = 1; step(1);
    check("R9 latched ov over oc", O_OVL);
    do_reset();
    ss_done = 1; fb_uv = 1; step(UVD);
    fb_uv = 0; ss_done = 0; fb_ov_low = 1; step(1);
    check("R9 soft ov over uv hiccup", O_OVS);
    fb_ov_low = 0; step(1);
    check("R9 uv hiccup resumes", O_UV);

    // R10 no restart under shutdown
    do_reset();
    for (int i = 0; i < OCN; i++) oc_tick(1);
    ss_done = 1; fb_uv = 1; step(UVD); fb_uv = 0;
    begin
      logic seen;
      seen = 0;
      for (int i = 0; i < HIC + 4; i++) begin
        step(1);
        if (restart_req) seen = 1;
      end
      n_chk++;
      if (seen) begin
        n_bad++;
        $display("FAIL R10: restart_req 1 expected 0 under shutdown");
      end
    end
    check("R10 shutdown steady", O_OC);

    report();
  end
endmodule